// File: doc/BRIEF.md
# Run-Time Width Memory Data Converter

This block joins a 32-bit application data port to a memory data path whose width (32, 16 or 8 bits) is picked by a live 2-bit select rather than fixed at build time. On the write side the application holds one 32-bit word and its active-low byte enables. The block shows the transfer engine one narrow slice of that word at a time, least significant slice first. Each slice carries only the enables of its own bytes. The application is told to advance only when the engine consumes the word's final slice.

On the read side the engine hands over narrow beats. The block packs them into a 32-bit word and presents that word with a one-cycle valid strobe. A last flag marks the word that holds the final beat of a burst. A start pulse on either side returns that side's slice position to the first slice of a word.

Top module: `memw_conv`

## Requirements
- R1: The width select encodes 00 as a 32-bit memory (one beat per word), 01 as 16-bit (two beats per word) and 10 or 11 as 8-bit (four beats per word).
- R2: On writes, beat k of a word carries application bytes k*L to k*L+L-1, where L is the number of bytes per beat. These bytes sit in the low lanes of `wr_beat_data`, and the unused upper lanes are driven as zero.
- R3: `wr_beat_be_n` carries the active-low enables of the same bytes in its low bits, and its unused upper bits are driven as 1 (disabled).
- R4: `app_wr_next` is high, in the same cycle, exactly when `wr_beat_next` consumes the final slice of the current word.
- R5: `app_wr_last` is high only in a cycle where `app_wr_next` is high and `wr_beat_last` is high.
- R6: On reads, accepted beats fill the word least significant slice first, from the low lanes of `rd_beat_data`, ignoring the upper lanes in narrow modes. The packed word and a single-cycle `app_rd_valid` appear in the cycle after the beat that completes the word.
- R7: `app_rd_last` rises with the valid of the word that holds the beat flagged by `rd_beat_last`. A beat flagged last that arrives before the word is full flushes the partial word, with its unfilled bytes as zero.
- R8: A `wr_start` or `rd_start` pulse returns that side to the first slice of a word, and a read start drops any partly packed word.
- R9: In reset, `app_rd_valid`, `app_rd_last` and `app_rd_data` are zero and both slice positions are at the first slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| width_sel | input | 2 | Memory width select (00 32-bit, 01 16-bit, 1x 8-bit) |
| wr_start | input | 1 | Write burst start pulse |
| wr_beat_next | input | 1 | Engine consumes the current write slice |
| wr_beat_last | input | 1 | Consumed slice is the final one of the burst |
| wr_beat_data | output | 32 | Current write slice, in the low lanes |
| wr_beat_be_n | output | 4 | Active-low enables of the current slice |
| app_wr_data | input | 32 | Application write word |
| app_wr_be_n | input | 4 | Application active-low byte enables |
| app_wr_next | output | 1 | Application advances to the next word |
| app_wr_last | output | 1 | Final write word of the burst consumed |
| rd_start | input | 1 | Read burst start pulse |
| rd_beat_ok | input | 1 | Read beat present |
| rd_beat_last | input | 1 | Read beat is the final one of the burst |
| rd_beat_data | input | 32 | Read beat, in the low lanes |
| app_rd_data | output | 32 | Packed read word |
| app_rd_valid | output | 1 | Packed read word valid, one cycle |
| app_rd_last | output | 1 | Word holds the final beat of the burst |

## Verification
The write outputs (`wr_beat_data`, `wr_beat_be_n`, `app_wr_next`, `app_wr_last`) respond to the held word and the slice position in the same cycle. The bench therefore sets inputs on the falling edge and samples one nanosecond later, before the rising edge advances the slice. The read outputs are registered and change on the rising edge that accepts the completing beat. The bench drives each beat across one rising edge and checks at the falling edge that follows. It then checks one cycle later that the valid strobe has dropped.

// File: rtl/memw_pkg.sv
// Shared constants and helpers for the run-time width converter.
// Assumes a four-byte application word; the byte width is a module parameter.
package memw_pkg;

    localparam int LANES = 4;

    // Bytes carried per memory beat for a given width select.
    function automatic int lanes_per_beat(input logic [1:0] ws);
        if (ws[1])
            return 1;
        else if (ws[0])
            return 2;
        else
            return LANES;
    endfunction

    // Memory beats needed to move one application word.
    function automatic int beats_per_word(input logic [1:0] ws);
        return LANES / lanes_per_beat(ws);
    endfunction

endpackage

// File: rtl/memw_slicer.sv
// Write path: presents the held application word as narrow slices.
// Slices leave least significant first and sit in the low lanes.
// Unused lanes read as zero data and disabled enables.
// Assumes wr_start never coincides with wr_beat_next.
module memw_slicer
    import memw_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              width_sel,
    input  logic                    wr_start,
    input  logic                    wr_beat_next,
    input  logic                    wr_beat_last,
    input  logic [BYTE_W*LANES-1:0] app_wr_data,
    input  logic [LANES-1:0]        app_wr_be_n,
    output logic [BYTE_W*LANES-1:0] beat_data,
    output logic [LANES-1:0]        beat_be_n,
    output logic                    app_wr_next,
    output logic                    app_wr_last
);
    localparam int CW = $clog2(LANES);

    logic [CW-1:0] slice_q;
    logic          final_slice;

    // Select the lanes of the current slice and flag the word's final slice.
    always_comb begin
        int lpb;
        int src;
        lpb         = lanes_per_beat(width_sel);
        final_slice = (int'(slice_q) >= beats_per_word(width_sel) - 1);
        beat_data   = '0;
        beat_be_n   = '1;
        for (int j = 0; j < LANES; j++) begin
            src = int'(slice_q) * lpb + j;
            if (j < lpb && src < LANES) begin
                beat_data[j*BYTE_W +: BYTE_W] = app_wr_data[src*BYTE_W +: BYTE_W];
                beat_be_n[j]                  = app_wr_be_n[src];
            end
        end
    end

    assign app_wr_next = wr_beat_next && final_slice;
    assign app_wr_last = app_wr_next && wr_beat_last;

    // Advance the slice position on each consumed beat; restart on a start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slice_q <= '0;
        else if (wr_start)
            slice_q <= '0;
        else if (wr_beat_next)
            slice_q <= final_slice ? '0 : slice_q + CW'(1);
    end

endmodule

// File: rtl/memw_packer.sv
// Read path: gathers narrow beats into a full word.
// A completed word is registered with a one-cycle valid.
// A beat flagged last flushes a partial word with zero in its unfilled bytes.
// Assumes rd_start never coincides with rd_beat_ok.
module memw_packer
    import memw_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              width_sel,
    input  logic                    rd_start,
    input  logic                    rd_beat_ok,
    input  logic                    rd_beat_last,
    input  logic [BYTE_W*LANES-1:0] rd_beat_data,
    output logic [BYTE_W*LANES-1:0] app_rd_data,
    output logic                    app_rd_valid,
    output logic                    app_rd_last
);
    localparam int CW     = $clog2(LANES);
    localparam int WORD_W = BYTE_W * LANES;

    logic [CW-1:0]     slice_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] merged;
    logic              word_done;

    // Merge the incoming beat into the partial word and decide if it closes it.
    always_comb begin
        int lpb;
        int dst;
        lpb    = lanes_per_beat(width_sel);
        merged = acc_q;
        for (int j = 0; j < LANES; j++) begin
            dst = int'(slice_q) * lpb + j;
            if (j < lpb && dst < LANES)
                merged[dst*BYTE_W +: BYTE_W] = rd_beat_data[j*BYTE_W +: BYTE_W];
        end
        word_done = rd_beat_ok &&
                    ((int'(slice_q) >= beats_per_word(width_sel) - 1) || rd_beat_last);
    end

    // Hold the partial word and slice position; publish finished words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slice_q      <= '0;
            acc_q        <= '0;
            app_rd_data  <= '0;
            app_rd_valid <= 1'b0;
            app_rd_last  <= 1'b0;
        end else begin
            app_rd_valid <= 1'b0;
            app_rd_last  <= 1'b0;
            if (rd_start) begin
                slice_q <= '0;
                acc_q   <= '0;
            end else if (rd_beat_ok) begin
                if (word_done) begin
                    app_rd_data  <= merged;
                    app_rd_valid <= 1'b1;
                    app_rd_last  <= rd_beat_last;
                    acc_q        <= '0;
                    slice_q      <= '0;
                end else begin
                    acc_q   <= merged;
                    slice_q <= slice_q + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/memw_conv.sv
// Top of the run-time width converter.
// Joins the write slicer and the read packer, which share only the width select.
// Assumes width_sel is held steady inside a word.
module memw_conv
    import memw_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              width_sel,
    input  logic                    wr_start,
    input  logic                    wr_beat_next,
    input  logic                    wr_beat_last,
    output logic [BYTE_W*LANES-1:0] wr_beat_data,
    output logic [LANES-1:0]        wr_beat_be_n,
    input  logic [BYTE_W*LANES-1:0] app_wr_data,
    input  logic [LANES-1:0]        app_wr_be_n,
    output logic                    app_wr_next,
    output logic                    app_wr_last,
    input  logic                    rd_start,
    input  logic                    rd_beat_ok,
    input  logic                    rd_beat_last,
    input  logic [BYTE_W*LANES-1:0] rd_beat_data,
    output logic [BYTE_W*LANES-1:0] app_rd_data,
    output logic                    app_rd_valid,
    output logic                    app_rd_last
);

    // Write direction: word to slices.
    memw_slicer #(.BYTE_W(BYTE_W)) u_slicer (
        .clk          (clk),
        .rst_n        (rst_n),
        .width_sel    (width_sel),
        .wr_start     (wr_start),
        .wr_beat_next (wr_beat_next),
        .wr_beat_last (wr_beat_last),
        .app_wr_data  (app_wr_data),
        .app_wr_be_n  (app_wr_be_n),
        .beat_data    (wr_beat_data),
        .beat_be_n    (wr_beat_be_n),
        .app_wr_next  (app_wr_next),
        .app_wr_last  (app_wr_last)
    );

    // Read direction: beats to word.
    memw_packer #(.BYTE_W(BYTE_W)) u_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .width_sel    (width_sel),
        .rd_start     (rd_start),
        .rd_beat_ok   (rd_beat_ok),
        .rd_beat_last (rd_beat_last),
        .rd_beat_data (rd_beat_data),
        .app_rd_data  (app_rd_data),
        .app_rd_valid (app_rd_valid),
        .app_rd_last  (app_rd_last)
    );

endmodule

// File: rtl/memw_conv_chk.sv
// Property checker for the width converter, attached by bind.
// Relates the handshake and flag ports of both directions over time.
module memw_conv_chk
    import memw_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       width_sel,
    input logic             wr_beat_next,
    input logic             wr_beat_last,
    input logic [LANES-1:0] wr_beat_be_n,
    input logic             app_wr_next,
    input logic             app_wr_last,
    input logic             rd_beat_ok,
    input logic             app_rd_valid,
    input logic             app_rd_last
);

    AST_WR_NEXT_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        app_wr_next |-> wr_beat_next); // R4

    AST_FULL_WIDTH_EVERY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (width_sel == 2'b00 && wr_beat_next) |-> app_wr_next); // R1

    AST_WR_LAST_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
        app_wr_last |-> (app_wr_next && wr_beat_last)); // R5

    AST_NARROW_UPPER_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (width_sel != 2'b00) |-> (&wr_beat_be_n[LANES-1:LANES/2])); // R3

    AST_BYTE_MODE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        width_sel[1] |-> (&wr_beat_be_n[LANES-1:1])); // R3

    AST_RD_VALID_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        app_rd_valid |-> $past(rd_beat_ok)); // R6

    AST_RD_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        app_rd_last |-> app_rd_valid); // R7

endmodule

bind memw_conv memw_conv_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/memw_conv_bench.sv
`timescale 1ns/1ps
module memw_conv_bench;

    typedef struct packed {
        logic [1:0]  ws;
        logic        st;
        logic [31:0] d;
        logic [3:0]  be;
        logic [31:0] ed;
        logic [3:0]  ebe;
        logic        en;
    } wvec_t;

    // Write beats: select, start, word, enables -> slice data, slice enables, advance.
    localparam wvec_t WV [12] = '{
        '{2'd0, 1'b1, 32'hA1B2C3D4, 4'b0101, 32'hA1B2C3D4, 4'b0101, 1'b1},
        '{2'd1, 1'b1, 32'hA1B2C3D4, 4'b0101, 32'h0000C3D4, 4'b1101, 1'b0},
        '{2'd1, 1'b0, 32'hA1B2C3D4, 4'b0101, 32'h0000A1B2, 4'b1101, 1'b1},
        '{2'd2, 1'b1, 32'h11223344, 4'b0110, 32'h00000044, 4'b1110, 1'b0},
        '{2'd2, 1'b0, 32'h11223344, 4'b0110, 32'h00000033, 4'b1111, 1'b0},
        '{2'd2, 1'b0, 32'h11223344, 4'b0110, 32'h00000022, 4'b1111, 1'b0},
        '{2'd2, 1'b0, 32'h11223344, 4'b0110, 32'h00000011, 4'b1110, 1'b1},
        '{2'd3, 1'b1, 32'hCAFEF00D, 4'b0000, 32'h0000000D, 4'b1110, 1'b0},
        '{2'd3, 1'b0, 32'hCAFEF00D, 4'b0000, 32'h000000F0, 4'b1110, 1'b0},
        '{2'd1, 1'b1, 32'h12345678, 4'b0011, 32'h00005678, 4'b1111, 1'b0},
        '{2'd1, 1'b0, 32'h12345678, 4'b0011, 32'h00001234, 4'b1100, 1'b1},
        '{2'd0, 1'b0, 32'h0F0F0F0F, 4'b1010, 32'h0F0F0F0F, 4'b1010, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  width_sel = 2'd0;
    logic        wr_start = 1'b0, wr_beat_next = 1'b0, wr_beat_last = 1'b0;
    logic [31:0] wr_beat_data;
    logic [3:0]  wr_beat_be_n;
    logic [31:0] app_wr_data = '0;
    logic [3:0]  app_wr_be_n = '1;
    logic        app_wr_next, app_wr_last;
    logic        rd_start = 1'b0, rd_beat_ok = 1'b0, rd_beat_last = 1'b0;
    logic [31:0] rd_beat_data = '0;
    logic [31:0] app_rd_data;
    logic        app_rd_valid, app_rd_last;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    memw_conv u_memw_conv (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_go();
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
    endtask

    // One read beat across one rising edge; returns at the following falling edge.
    task automatic rd_put(input logic [31:0] d, input logic last);
        rd_beat_ok   = 1'b1;
        rd_beat_data = d;
        rd_beat_last = last;
        @(negedge clk);
        rd_beat_ok   = 1'b0;
        rd_beat_last = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs in reset
        chk("R9", {31'd0, app_rd_valid}, 32'd0);
        chk("R9", {31'd0, app_rd_last}, 32'd0);
        chk("R9", app_rd_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R8: table of write slices
        for (int i = 0; i < 12; i++) begin
            width_sel   = WV[i].ws;
            app_wr_data = WV[i].d;
            app_wr_be_n = WV[i].be;
            if (WV[i].st) begin
                wr_beat_next = 1'b0;
                wr_start     = 1'b1;
                @(negedge clk);
                wr_start = 1'b0;
            end
            wr_beat_next = 1'b1;
            #1;
            chk("R2", wr_beat_data, WV[i].ed);
            chk("R3", {28'd0, wr_beat_be_n}, {28'd0, WV[i].ebe});
            chk("R4", {31'd0, app_wr_next}, {31'd0, WV[i].en});
            @(negedge clk);
        end
        wr_beat_next = 1'b0;

        // R5: last flag only on the word-completing slice
        width_sel   = 2'b01;
        app_wr_data = 32'h55667788;
        wr_start    = 1'b1;
        @(negedge clk);
        wr_start     = 1'b0;
        wr_beat_next = 1'b1;
        wr_beat_last = 1'b1;
        #1;
        chk("R5", {31'd0, app_wr_last}, 32'd0);
        @(negedge clk);
        #1;
        chk("R5", {31'd0, app_wr_last}, 32'd1);
        @(negedge clk);
        wr_beat_next = 1'b0;
        wr_beat_last = 1'b0;
        #1;
        chk("R5", {31'd0, app_wr_last}, 32'd0);

        // R6: 8-bit read, junk in upper lanes
        width_sel = 2'b10;
        rd_go();
        rd_put(32'hFFFFFF44, 1'b0);
        chk("R6", {31'd0, app_rd_valid}, 32'd0);
        rd_put(32'hEEEEEE33, 1'b0);
        rd_put(32'hDDDDDD22, 1'b0);
        chk("R6", {31'd0, app_rd_valid}, 32'd0);
        rd_put(32'hCCCCCC11, 1'b0);
        chk("R6", {31'd0, app_rd_valid}, 32'd1);
        chk("R6", app_rd_data, 32'h11223344);
        chk("R7", {31'd0, app_rd_last}, 32'd0);
        @(negedge clk);
        chk("R6", {31'd0, app_rd_valid}, 32'd0);

        // R7: 16-bit read ending on a full word
        width_sel = 2'b01;
        rd_go();
        rd_put(32'hABCD5678, 1'b0);
        rd_put(32'h00001234, 1'b1);
        chk("R6", app_rd_data, 32'h12345678);
        chk("R7", {31'd0, app_rd_last}, 32'd1);

        // R1 R6: 32-bit back-to-back beats
        width_sel = 2'b00;
        rd_go();
        rd_put(32'hDEADBEEF, 1'b0);
        chk("R1", {31'd0, app_rd_valid}, 32'd1);
        chk("R6", app_rd_data, 32'hDEADBEEF);
        chk("R7", {31'd0, app_rd_last}, 32'd0);
        rd_put(32'h01020304, 1'b1);
        chk("R1", {31'd0, app_rd_valid}, 32'd1);
        chk("R6", app_rd_data, 32'h01020304);
        chk("R7", {31'd0, app_rd_last}, 32'd1);

        // R7: partial word flushed on last beat in 8-bit mode
        width_sel = 2'b11;
        rd_go();
        rd_put(32'h000000AA, 1'b0);
        rd_put(32'h000000BB, 1'b1);
        chk("R7", {31'd0, app_rd_valid}, 32'd1);
        chk("R7", app_rd_data, 32'h0000BBAA);
        chk("R7", {31'd0, app_rd_last}, 32'd1);

        // R8: read start drops a partial word
        width_sel = 2'b01;
        rd_go();
        rd_put(32'h00001111, 1'b0);
        rd_go();
        chk("R8", {31'd0, app_rd_valid}, 32'd0);
        rd_put(32'h00002222, 1'b0);
        rd_put(32'h00003333, 1'b1);
        chk("R8", app_rd_data, 32'h33332222);
        chk("R8", {31'd0, app_rd_valid}, 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule